// File: doc/BRIEF.md
# Dual-Input Tachometer Capture Timer

This block times the pulses from two fan tachometer inputs, A and B. A shared prescaler divides the system clock and drives two 16-bit down-counters. Counter 1 serves input A and counter 2 serves input B. Each counter starts at 0xFFFF. On a falling edge of its synchronised input, the counter's current value is latched into a capture register, and a pending flag is raised. Software reads the period as 0xFFFF minus the capture. It then writes a one to the capture flag's clear bit, which also reloads that counter to 0xFFFF so the next period can be measured.

Each counter also has an equality compare against a programmable value. When the counter steps onto that value, a timeout flag is raised. Firmware loads the compare with 0xFFFF minus the longest allowed period, so a stalled or absent fan shows up as a timeout rather than a capture. The four flags are write-one-to-clear and each has an enable. One interrupt line combines them.

Registers are byte-wide and sit on a simple write strobe with a combinational read mux. The map is: 0x00 prescale, 0x01 mode, 0x02 counter run, 0x03 compare config, 0x04 interrupt enable, 0x05 flags (read) and flag clear (write). Each 16-bit value is split into a low byte at the even address and a high byte at the odd address: counters at 0x08 and 0x0A, captures at 0x0C and 0x0E, compares at 0x10 and 0x12.

Top module: `tach_capture_timer`

## Requirements
- R1: After reset, both counters read 0xFFFF, the captures, compares and flags read 0x00, and irq is low.
- R2: With prescale value P at address 0x00, a running counter decrements exactly once every P+1 clocks, counted from the write that starts it.
- R3: Counter 1 runs only while bit 0 of address 0x02 is set, and counter 2 only while bit 3 is set. A stopped counter holds its value.
- R4: A running counter that reaches 0x0000 stays at 0x0000 and does not wrap.
- R5: A falling edge on tach_a latches counter 1 into capture A and sets flag bit 0, and a falling edge on tach_b latches counter 2 into capture B and sets flag bit 1. Each needs mode (0x01) bit 2 set plus the input's enable (bit 5 for A, bit 6 for B). A rising edge captures nothing.
- R6: With an input's enable bit clear, or with mode bit 2 clear, a falling edge leaves that capture register and its flag unchanged.
- R7: A running counter sets its timeout flag (bit 4 for counter 1, bit 5 for counter 2) on the tick that steps it onto its compare value. This needs compare config (0x03) bit 2 for counter 1 or bit 6 for counter 2. With that bit clear, no timeout flag is set.
- R8: Writing to address 0x05 clears each flag whose data bit is one and leaves the others. Writing 0x3F clears all four flags.
- R9: Clearing capture flag bit 0 reloads counter 1 to 0xFFFF, and clearing bit 1 reloads counter 2. Clearing a timeout flag leaves the counter value unchanged.
- R10: irq is high exactly when some flag is set whose bit is also set in the enable register at 0x04 (same bit positions).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 8 | Read data for rd_addr (combinational) |
| tach_a | input | 1 | Tachometer input A (asynchronous) |
| tach_b | input | 1 | Tachometer input B (asynchronous) |
| irq | output | 1 | Combined interrupt request |

## Verification
Most internal faults in this block show up at the ports within a few cycles:

- A wrong counter value appears on the next counter read, and again in the next capture.
- A wrong prescaler phase shifts the count read after a timed run by one or more steps.
- A missing reload leaves the counter at its old value right after a capture flag is cleared, instead of 0xFFFF.
- A wrong flag appears on irq in the same cycle once its enable is set.
- A timeout raised at the wrong step shows as the flag rising one tick early or late relative to the compare value.

// File: rtl/tct_pkg.sv
package tct_pkg;
  // register addresses
  localparam int REG_PRE    = 0;
  localparam int REG_MODE   = 1;
  localparam int REG_RUN    = 2;
  localparam int REG_CMPCFG = 3;
  localparam int REG_IEN    = 4;
  localparam int REG_FLAG   = 5;
  localparam int REG_CNT0   = 8;   // counter n at REG_CNT0 + 2n (lo, hi)
  localparam int REG_CAP0   = 12;  // capture n at REG_CAP0 + 2n
  localparam int REG_CMP0   = 16;  // compare n at REG_CMP0 + 2n

  // field positions
  localparam int MODE_CAPTURE = 2;
  localparam int MODE_EN_A    = 5;
  localparam int MODE_EN_B    = 6;
  localparam int RUN_1        = 0;
  localparam int RUN_2        = 3;
  localparam int EQ_1         = 2;
  localparam int EQ_2         = 6;
  localparam int FL_CAP_A     = 0;
  localparam int FL_CAP_B     = 1;
  localparam int FL_TO_1      = 4;
  localparam int FL_TO_2      = 5;
  localparam logic [7:0] FLAG_MASK = 8'h33;

  localparam int NUM_CH = 2;
endpackage

// File: rtl/tct_prescaler.sv
module tct_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  logic [PRE_W-1:0] pcnt_q, pcnt_d;
  logic             wrap;

  assign wrap = (pcnt_q >= div);
  assign tick = active & wrap;

  always_comb begin
    pcnt_d = pcnt_q;
    if (!active)   pcnt_d = '0;
    else if (wrap) pcnt_d = '0;
    else           pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/tct_edge_sync.sv
module tct_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  localparam int HIST = STAGES + 1;
  logic [HIST-1:0] sh_q, sh_d;

  assign sh_d = {sh_q[HIST-2:0], din};
  // falling edge of the last synchronised stage
  assign fall = sh_q[HIST-1] & ~sh_q[HIST-2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end
endmodule

// File: rtl/tct_channel.sv
module tct_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             cap_arm,
  input  logic             eq_en,
  input  logic             fall,
  input  logic             reload,
  input  logic             cnt_wr,
  input  logic             cmp_wr,
  input  logic             wr_hi,
  input  logic [7:0]       wr_byte,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cap_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             cap_evt,
  output logic             to_evt
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cap_q, cap_d, cmp_q, cmp_d, cnt_dec;
  logic             step;

  assign step    = run & tick & (cnt_q != '0);
  assign cnt_dec = cnt_q - 1'b1;
  assign cap_evt = cap_arm & fall;
  assign to_evt  = eq_en & step & ~reload & ~cnt_wr & (cnt_dec == cmp_q);

  always_comb begin
    cnt_d = cnt_q;
    if (reload)
      cnt_d = '1;
    else if (cnt_wr) begin
      if (wr_hi) cnt_d[CNT_W-1:8] = wr_byte[CNT_W-9:0];
      else       cnt_d[7:0]       = wr_byte;
    end else if (step)
      cnt_d = cnt_dec;
  end

  always_comb begin
    cap_d = cap_evt ? cnt_q : cap_q;
  end

  always_comb begin
    cmp_d = cmp_q;
    if (cmp_wr) begin
      if (wr_hi) cmp_d[CNT_W-1:8] = wr_byte[CNT_W-9:0];
      else       cmp_d[7:0]       = wr_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      cap_q <= '0;
      cmp_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      cap_q <= cap_d;
      cmp_q <= cmp_d;
    end
  end

  assign cnt_o = cnt_q;
  assign cap_o = cap_q;
  assign cmp_o = cmp_q;
endmodule

// File: rtl/tach_capture_timer.sv
module tach_capture_timer
  import tct_pkg::*;
#(
  parameter int PRE_W       = 8,
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              tach_a,
  input  logic              tach_b,
  output logic              irq
);
  localparam int NBYTE = CNT_W / 8;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  // control registers
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [7:0] mode_q, mode_d, run_q, run_d, cmpcfg_q, cmpcfg_d, ien_q, ien_d;
  logic [7:0] pend_q, pend_d, flag_clr, flag_set;

  always_comb begin
    pre_d    = pre_q;
    mode_d   = mode_q;
    run_d    = run_q;
    cmpcfg_d = cmpcfg_q;
    ien_d    = ien_q;
    if (wr_en) begin
      case (int'(wr_addr))
        REG_PRE:    pre_d    = wr_data[PRE_W-1:0];
        REG_MODE:   mode_d   = wr_data;
        REG_RUN:    run_d    = wr_data;
        REG_CMPCFG: cmpcfg_d = wr_data;
        REG_IEN:    ien_d    = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pre_q    <= '0;
      mode_q   <= '0;
      run_q    <= '0;
      cmpcfg_q <= '0;
      ien_q    <= '0;
    end else begin
      pre_q    <= pre_d;
      mode_q   <= mode_d;
      run_q    <= run_d;
      cmpcfg_q <= cmpcfg_d;
      ien_q    <= ien_d;
    end
  end

  // per-channel wiring
  logic [NUM_CH-1:0]            ch_run, ch_arm, ch_eq, ch_fall, reload;
  logic [NUM_CH-1:0]            cnt_wr, cmp_wr, cap_evt, to_evt;
  logic [NUM_CH-1:0]            tach_in;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_all, cap_all, cmp_all;
  logic                         tick;

  assign tach_in  = {tach_b, tach_a};
  assign flag_clr = (wr_en && int'(wr_addr) == REG_FLAG) ? (wr_data & FLAG_MASK) : 8'h00;

  tct_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk    (clk),
    .rst_n  (srst_n),
    .active (|ch_run),
    .div    (pre_q),
    .tick   (tick)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int RUN_BIT = (ch == 0) ? RUN_1     : RUN_2;
    localparam int EN_BIT  = (ch == 0) ? MODE_EN_A : MODE_EN_B;
    localparam int EQ_BIT  = (ch == 0) ? EQ_1      : EQ_2;
    localparam int CAP_FL  = (ch == 0) ? FL_CAP_A  : FL_CAP_B;
    localparam logic [ADDR_W-2:0] CNT_PAIR = (ADDR_W-1)'((REG_CNT0 >> 1) + ch);
    localparam logic [ADDR_W-2:0] CMP_PAIR = (ADDR_W-1)'((REG_CMP0 >> 1) + ch);

    assign ch_run[ch] = run_q[RUN_BIT];
    assign ch_arm[ch] = mode_q[MODE_CAPTURE] & mode_q[EN_BIT];
    assign ch_eq[ch]  = cmpcfg_q[EQ_BIT];
    assign reload[ch] = flag_clr[CAP_FL];
    assign cnt_wr[ch] = wr_en && (wr_addr[ADDR_W-1:1] == CNT_PAIR);
    assign cmp_wr[ch] = wr_en && (wr_addr[ADDR_W-1:1] == CMP_PAIR);

    tct_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (srst_n),
      .din   (tach_in[ch]),
      .fall  (ch_fall[ch])
    );

    tct_channel #(.CNT_W(CNT_W)) u_chan (
      .clk     (clk),
      .rst_n   (srst_n),
      .tick    (tick),
      .run     (ch_run[ch]),
      .cap_arm (ch_arm[ch]),
      .eq_en   (ch_eq[ch]),
      .fall    (ch_fall[ch]),
      .reload  (reload[ch]),
      .cnt_wr  (cnt_wr[ch]),
      .cmp_wr  (cmp_wr[ch]),
      .wr_hi   (wr_addr[0]),
      .wr_byte (wr_data),
      .cnt_o   (cnt_all[ch]),
      .cap_o   (cap_all[ch]),
      .cmp_o   (cmp_all[ch]),
      .cap_evt (cap_evt[ch]),
      .to_evt  (to_evt[ch])
    );
  end

  // pending flags: a new event wins over a clear in the same cycle
  always_comb begin
    flag_set           = 8'h00;
    flag_set[FL_CAP_A] = cap_evt[0];
    flag_set[FL_CAP_B] = cap_evt[1];
    flag_set[FL_TO_1]  = to_evt[0];
    flag_set[FL_TO_2]  = to_evt[1];
    pend_d = ((pend_q & ~flag_clr) | flag_set) & FLAG_MASK;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign irq = |(pend_q & ien_q);

  // read mux
  always_comb begin
    rd_data = 8'h00;
    case (int'(rd_addr))
      REG_PRE:    rd_data = 8'(pre_q);
      REG_MODE:   rd_data = mode_q;
      REG_RUN:    rd_data = run_q;
      REG_CMPCFG: rd_data = cmpcfg_q;
      REG_IEN:    rd_data = ien_q;
      REG_FLAG:   rd_data = pend_q;
      default: begin
        for (int ch = 0; ch < NUM_CH; ch++) begin
          for (int b = 0; b < NBYTE; b++) begin
            if (int'(rd_addr) == REG_CNT0 + 2*ch + b) rd_data = cnt_all[ch][8*b +: 8];
            if (int'(rd_addr) == REG_CAP0 + 2*ch + b) rd_data = cap_all[ch][8*b +: 8];
            if (int'(rd_addr) == REG_CMP0 + 2*ch + b) rd_data = cmp_all[ch][8*b +: 8];
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/tct_checks.sv
module tct_checks
  import tct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                            clk,
  input logic                            srst_n,
  input logic [NUM_CH-1:0]               ch_run,
  input logic [NUM_CH-1:0]               cnt_wr,
  input logic [NUM_CH-1:0]               reload,
  input logic [NUM_CH-1:0]               cap_evt,
  input logic [NUM_CH-1:0]               to_evt,
  input logic [NUM_CH-1:0][CNT_W-1:0]    cnt_all,
  input logic [7:0]                      pend_q
);
  // R3: a stopped counter with no write or reload holds
  a_r3_stopped_hold: assert property (@(posedge clk) disable iff (!srst_n)
    (!ch_run[0] && !cnt_wr[0] && !reload[0]) |=> (cnt_all[0] == $past(cnt_all[0])));

  // R2: without write or reload a counter moves by at most one step
  a_r2_single_step: assert property (@(posedge clk) disable iff (!srst_n)
    (!cnt_wr[1] && !reload[1]) |=>
      (cnt_all[1] == $past(cnt_all[1]) || cnt_all[1] == CNT_W'($past(cnt_all[1]) - 1'b1)));

  // R4: zero is sticky while running
  a_r4_floor: assert property (@(posedge clk) disable iff (!srst_n)
    (cnt_all[0] == '0 && !cnt_wr[0] && !reload[0]) |=> (cnt_all[0] == '0));

  // R5: a capture event raises its pending flag
  a_r5_cap_flag_a: assert property (@(posedge clk) disable iff (!srst_n)
    cap_evt[0] |=> pend_q[FL_CAP_A]);
  a_r5_cap_flag_b: assert property (@(posedge clk) disable iff (!srst_n)
    cap_evt[1] |=> pend_q[FL_CAP_B]);

  // R7: a compare match raises its timeout flag
  a_r7_timeout_flag: assert property (@(posedge clk) disable iff (!srst_n)
    to_evt[1] |=> pend_q[FL_TO_2]);

  // R9: clearing a capture flag reloads the counter
  a_r9_reload: assert property (@(posedge clk) disable iff (!srst_n)
    reload[0] |=> (cnt_all[0] == '1));
endmodule

bind tach_capture_timer tct_checks #(.CNT_W(CNT_W)) u_checks (
  .clk     (clk),
  .srst_n  (srst_n),
  .ch_run  (ch_run),
  .cnt_wr  (cnt_wr),
  .reload  (reload),
  .cap_evt (cap_evt),
  .to_evt  (to_evt),
  .cnt_all (cnt_all),
  .pend_q  (pend_q)
);

// File: tb/sim_tach_capture_timer.sv
module sim_tach_capture_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  // capture vectors: {channel, counter preset}; expected capture = preset
  localparam logic [16:0] CAP_VEC [4] = '{
    {1'b0, 16'h1234}, {1'b1, 16'hBEEF}, {1'b0, 16'h0001}, {1'b1, 16'hFFFE}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [4:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic       tach_a, tach_b, irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tach_capture_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tach_a(tach_a), .tach_b(tach_b), .irq(irq)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd8(input int a, output int v);
    @(negedge clk);
    rd_addr = 5'(a);
    #1 v = int'(rd_data);
  endtask

  task automatic rd16(input int a, output int v);
    int lo, hi;
    rd8(a, lo);
    rd8(a + 1, hi);
    v = (hi << 8) | lo;
  endtask

  task automatic wr16(input int a, input int v);
    wr(a, v & 8'hFF);
    wr(a + 1, (v >> 8) & 8'hFF);
  endtask

  task automatic drive_tach(input int ch, input logic lvl);
    @(negedge clk);
    if (ch == 0) tach_a = lvl; else tach_b = lvl;
    repeat (6) @(posedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v, w;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    tach_a = 1'b1; tach_b = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state
    rd16(8, v);  check("R1 counter1 reset", v, 16'hFFFF);
    rd16(10, v); check("R1 counter2 reset", v, 16'hFFFF);
    rd16(12, v); check("R1 captureA reset", v, 0);
    rd8(5, v);   check("R1 flags reset", v, 0);
    check("R1 irq reset", int'(irq), 0);

    // R5, R9: capture vector table, counters stopped
    wr(1, 8'h64);
    foreach (CAP_VEC[i]) begin
      int ch, val;
      ch  = int'(CAP_VEC[i][16]);
      val = int'(CAP_VEC[i][15:0]);
      wr16(8 + 2*ch, val);
      drive_tach(ch, 1'b0);
      rd16(12 + 2*ch, v); check("R5 capture value", v, val);
      rd8(5, v);          check("R5 capture flag", v, 1 << ch);
      drive_tach(ch, 1'b1);
      rd8(5, v);          check("R5 rising edge no new flag", v, 1 << ch);
      wr(5, 1 << ch);
      rd8(5, v);          check("R8 capture flag cleared", v, 0);
      rd16(8 + 2*ch, v);  check("R9 reload on capture clear", v, 16'hFFFF);
    end

    // R6: input A disabled
    wr(1, 8'h44);
    wr16(8, 16'h0777);
    drive_tach(0, 1'b0); drive_tach(0, 1'b1);
    rd8(5, v);   check("R6 disabled input no flag", v, 0);
    rd16(12, v); check("R6 disabled input capture kept", v, 16'hFFFE & 16'h0001 | 16'h0001);
    // R6: capture mode bit off
    wr(1, 8'h60);
    drive_tach(1, 1'b0); drive_tach(1, 1'b1);
    rd8(5, v);   check("R6 mode off no flag", v, 0);
    rd16(14, v); check("R6 mode off capture kept", v, 16'hFFFE);

    // R2: prescale 3, run 16 clocks -> 4 steps
    wr16(8, 16'h0100);
    wr(0, 3);
    wr(2, 8'h01);
    repeat (16) @(posedge clk);
    wr(2, 8'h00);
    rd16(8, v); check("R2 prescale divide", v, 16'h00FC);
    // R3: stopped counter holds, other counter untouched
    repeat (10) @(posedge clk);
    rd16(8, v);  check("R3 stopped counter holds", v, 16'h00FC);
    rd16(10, v); check("R3 counter2 idle without run bit", v, 16'hFFFF);

    // R7: timeout on counter 1 at compare
    wr(0, 0);
    wr16(16, 16'hAFFF);
    wr(3, 8'h04);
    wr16(8, 16'hB002);
    wr(2, 8'h01);
    repeat (2) @(posedge clk);
    @(negedge clk); rd_addr = 5'd5; #1 v = int'(rd_data);
    check("R7 no timeout before compare", v, 0);
    @(posedge clk);
    @(negedge clk); #1 v = int'(rd_data);
    check("R7 timeout flag at compare", v, 8'h10);
    wr(2, 8'h00);
    // R10: interrupt enable
    check("R10 irq masked", int'(irq), 0);
    wr(4, 8'h10);
    @(negedge clk); check("R10 irq enabled flag", int'(irq), 1);
    // R9: timeout clear does not reload
    rd16(8, w);
    wr(5, 8'h10);
    rd16(8, v); check("R9 timeout clear keeps counter", v, w);
    rd8(5, v);  check("R8 timeout flag cleared", v, 0);
    check("R10 irq low after clear", int'(irq), 0);

    // R7: counter 2 with compare disabled, then enabled
    wr16(18, 16'hFFF0);
    wr16(10, 16'hFFF4);
    wr(2, 8'h08);
    repeat (8) @(posedge clk);
    wr(2, 8'h00);
    rd8(5, v); check("R7 compare disabled no timeout", v, 0);
    wr(3, 8'h40);
    wr16(10, 16'hFFF4);
    wr(2, 8'h08);
    repeat (8) @(posedge clk);
    wr(2, 8'h00);
    rd8(5, v); check("R7 counter2 timeout flag", v, 8'h20);

    // R4: saturation at zero
    wr16(8, 16'h0002);
    wr(2, 8'h01);
    repeat (10) @(posedge clk);
    wr(2, 8'h00);
    rd16(8, v); check("R4 counter holds at zero", v, 0);

    // R8: 0x3F clears everything
    wr(1, 8'h64);
    drive_tach(0, 1'b0); drive_tach(1, 1'b0);
    rd8(5, v); check("R8 flags before bulk clear", v, 8'h23);
    wr(5, 8'h3F);
    rd8(5, v); check("R8 bulk clear", v, 0);
    drive_tach(0, 1'b1); drive_tach(1, 1'b1);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule